// File: doc/BRIEF.md
# Phase-Accumulating Counter Channel

This block is one counter channel built around a phase accumulator. Three registers are loaded through a strobed write port: a control word that picks the mode and one of several input pins, a frequency addend, and the phase value. On each clock where the current mode's condition is true, the addend is added to the phase. The phase can be read at any time.

In duty mode the condition is always true. The carry out of the phase addition is registered and sent to the output pin, so an addend of 2^28 gives a one-clock pulse every 16 clocks. The two logic modes count on a registered sample of the selected input pin, taken either while it is high or while it is low.

The sample register is never cleared. It starts at a fixed power-up level and it holds its value whenever no logic mode is active. Software must therefore write the control word before it loads a nonzero addend. If the addend is loaded first, the stale sample can add one spurious addend.

Top module: `phase_ctr_chan`

## Requirements
- R1: While rst_ni is low, the mode, pin select, addend and phase are zero, so phase_o reads 0 and pin_o is 0.
- R2: With mode field 0 (off) the phase holds its value, except for a direct write, and pin_o is 0.
- R3: With mode field 1 (duty) the phase gains the addend on every clock. pin_o shows the carry of that addition one clock later. With addend 0x1000_0000, pin_o is high on exactly 4 of 64 consecutive clocks.
- R4: With mode field 2 the phase gains the addend on a clock only when the registered sample of the selected pin is 1. The phase therefore moves one clock after the pin rises.
- R5: With mode field 3 the phase gains the addend on a clock only when the registered sample of the selected pin is 0.
- R6: Control bits [10:8] select which bit of pins_i is sampled. Activity on the other pins has no effect on the phase.
- R7: The sample register is not reset. It powers up at 1 and is loaded only while a logic mode is active. If a nonzero addend is written before mode 2 is enabled, exactly one extra addend is added on the first clock in that mode.
- R8: If mode 2 is written first and the addend is written on the following clock, no extra addend is added, even when the stale sample is 1.
- R9: A write to the addend takes effect on the next clock. An accumulation on the write clock itself still uses the old addend.
- R10: A direct phase write (select 2) takes priority over accumulation on the same clock and clears the pending carry, so pin_o is 0 on the next cycle.
- R11: A write with select 3 changes no register.
- R12: pin_o is 0 in both logic modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| wr_sel_i | input | 2 | Register select: 0 control, 1 addend, 2 phase, 3 none |
| wr_data_i | input | DATA_W | Write data. Control word: mode in [1:0], pin select in [10:8] |
| pins_i | input | NUM_PINS | Input pins that can be sampled |
| phase_o | output | DATA_W | Current phase value |
| pin_o | output | 1 | Duty-mode carry output |

## Verification
The hardest case to reach is the ghost increment. It needs a stale sample of 1, a nonzero addend already loaded, and the mode switched on in a single exact write order. The stimulus uses the power-up level once. It then recreates a stale 1 deliberately: it runs mode 2 with the pin high, turns the mode off while the pin is still high, and then drives the pin low. With the stale 1 in place, it runs both write orders and checks that the addend-first order gives exactly one extra addend and the control-first order gives none. A behavioural model that carries its own copy of the sample state tracks every clock of these sequences.

// File: rtl/phase_ctr_pkg.sv
`timescale 1ns/1ps
package phase_ctr_pkg;
  typedef enum logic [1:0] {
    MODE_OFF      = 2'd0,
    MODE_DUTY     = 2'd1,
    MODE_LOGIC_HI = 2'd2,
    MODE_LOGIC_LO = 2'd3
  } ctr_mode_e;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_FREQ  = 2'd1,
    SEL_PHASE = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int unsigned MODE_LSB   = 0;
  localparam int unsigned PINSEL_LSB = 8;
endpackage

// File: rtl/ctr_regs.sv
`timescale 1ns/1ps
module ctr_regs
  import phase_ctr_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned PIN_SEL_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_sel_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  output ctr_mode_e            mode_o,
  output logic [PIN_SEL_W-1:0] pin_sel_o,
  output logic [DATA_W-1:0]    freq_o,
  output logic                 phase_we_o
);
  logic ctrl_we, freq_we;

  always_comb begin
    ctrl_we    = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_CTRL);
    freq_we    = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_FREQ);
    phase_we_o = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_PHASE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o    <= MODE_OFF;
      pin_sel_o <= '0;
    end else if (ctrl_we) begin
      mode_o    <= ctr_mode_e'(wr_data_i[MODE_LSB +: 2]);
      pin_sel_o <= wr_data_i[PINSEL_LSB +: PIN_SEL_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      freq_o <= '0;
    else if (freq_we) freq_o <= wr_data_i;
  end
endmodule

// File: rtl/ctr_cond.sv
`timescale 1ns/1ps
module ctr_cond
  import phase_ctr_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 8,
  parameter int unsigned PIN_SEL_W = 3,
  parameter bit          SAMP_INIT = 1'b1
) (
  input  logic                 clk_i,
  input  ctr_mode_e            mode_i,
  input  logic [PIN_SEL_W-1:0] pin_sel_i,
  input  logic [NUM_PINS-1:0]  pins_i,
  output logic                 samp_o,
  output logic                 cond_o
);
  logic pin_now, logic_mode;
  // deliberately without reset: holds its level across reset and idle
  logic samp_q = SAMP_INIT;

  assign pin_now    = pins_i[pin_sel_i];
  assign logic_mode = (mode_i == MODE_LOGIC_HI) || (mode_i == MODE_LOGIC_LO);

  always_ff @(posedge clk_i) begin
    if (logic_mode) samp_q <= pin_now;
  end

  always_comb begin
    unique case (mode_i)
      MODE_DUTY:     cond_o = 1'b1;
      MODE_LOGIC_HI: cond_o = samp_q;
      MODE_LOGIC_LO: cond_o = ~samp_q;
      default:       cond_o = 1'b0;
    endcase
  end

  assign samp_o = samp_q;
endmodule

// File: rtl/ctr_accum.sv
`timescale 1ns/1ps
module ctr_accum #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cond_i,
  input  logic              duty_i,
  input  logic [DATA_W-1:0] freq_i,
  input  logic              phase_we_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] phase_o,
  output logic              pin_o
);
  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] phase_q;
  logic              carry_q;

  assign sum = {1'b0, phase_q} + {1'b0, freq_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      carry_q <= 1'b0;
    end else if (phase_we_i) begin
      phase_q <= wr_data_i;
      carry_q <= 1'b0;
    end else if (cond_i) begin
      phase_q <= sum[DATA_W-1:0];
      carry_q <= duty_i & sum[DATA_W];
    end else begin
      carry_q <= 1'b0;
    end
  end

  assign phase_o = phase_q;
  assign pin_o   = carry_q & duty_i;
endmodule

// File: rtl/phase_ctr_chan.sv
`timescale 1ns/1ps
module phase_ctr_chan
  import phase_ctr_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_PINS  = 8,
  parameter bit          SAMP_INIT = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_sel_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [NUM_PINS-1:0] pins_i,
  output logic [DATA_W-1:0]   phase_o,
  output logic                pin_o
);
  localparam int unsigned PIN_SEL_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  ctr_mode_e            mode;
  logic [PIN_SEL_W-1:0] pin_sel;
  logic [DATA_W-1:0]    freq;
  logic                 phase_we, samp, cond, duty;

  assign duty = (mode == MODE_DUTY);

  ctr_regs #(.DATA_W(DATA_W), .PIN_SEL_W(PIN_SEL_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .mode_o(mode), .pin_sel_o(pin_sel), .freq_o(freq), .phase_we_o(phase_we)
  );

  ctr_cond #(.NUM_PINS(NUM_PINS), .PIN_SEL_W(PIN_SEL_W), .SAMP_INIT(SAMP_INIT)) u_cond (
    .clk_i, .mode_i(mode), .pin_sel_i(pin_sel), .pins_i,
    .samp_o(samp), .cond_o(cond)
  );

  ctr_accum #(.DATA_W(DATA_W)) u_accum (
    .clk_i, .rst_ni, .cond_i(cond), .duty_i(duty), .freq_i(freq),
    .phase_we_i(phase_we), .wr_data_i, .phase_o, .pin_o
  );
endmodule

// File: rtl/phase_ctr_chan_chk.sv
`timescale 1ns/1ps
module phase_ctr_chan_chk
  import phase_ctr_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned PIN_SEL_W = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_en_i,
  input logic [1:0]           wr_sel_i,
  input logic [DATA_W-1:0]    wr_data_i,
  input logic [DATA_W-1:0]    phase_o,
  input logic                 pin_o,
  input ctr_mode_e            mode_i,
  input logic [PIN_SEL_W-1:0] pin_sel_i,
  input logic [DATA_W-1:0]    freq_i,
  input logic                 samp_i
);
  logic ph_wr;
  assign ph_wr = wr_en_i && (wr_sel_i == 2'd2);

  p_off_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_OFF && !ph_wr) |=> $stable(phase_o));

  p_duty_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_DUTY && !ph_wr) |=> (phase_o == $past(phase_o) + $past(freq_i)));

  p_hi_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LOGIC_HI && !samp_i && !ph_wr) |=> $stable(phase_o));

  p_lo_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LOGIC_LO && samp_i && !ph_wr) |=> $stable(phase_o));

  p_phase_wr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_wr |=> (phase_o == $past(wr_data_i)) && !pin_o);

  p_sel_ignore_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd3) |=> $stable(mode_i) && $stable(freq_i) && $stable(pin_sel_i));

  p_pin_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_DUTY) |-> !pin_o);
endmodule

bind phase_ctr_chan phase_ctr_chan_chk #(.DATA_W(DATA_W), .PIN_SEL_W(PIN_SEL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .wr_data_i(wr_data_i), .phase_o(phase_o), .pin_o(pin_o), .mode_i(mode),
  .pin_sel_i(pin_sel), .freq_i(freq), .samp_i(samp)
);

// File: tb/phase_ctr_chan_bench.sv
`timescale 1ns/1ps
module phase_ctr_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [31:0] wdata = '0;
  logic [7:0]  pins = '0;
  logic [31:0] phase;
  logic        pin;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  phase_ctr_chan u_phase_ctr_chan (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_sel_i(sel),
    .wr_data_i(wdata), .pins_i(pins), .phase_o(phase), .pin_o(pin)
  );

  // behavioural reference
  int unsigned m_mode = 0, m_psel = 0;
  logic [31:0] m_freq = '0, m_phase = '0;
  bit          m_samp = 1'b1, m_carry = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_psel = 0; m_freq = '0; m_phase = '0; m_carry = 1'b0;
    end else begin
      bit c, ns;
      logic [32:0] s;
      c  = (m_mode == 1) || (m_mode == 2 && m_samp) || (m_mode == 3 && !m_samp);
      s  = {1'b0, m_phase} + {1'b0, m_freq};
      ns = (m_mode >= 2) ? pins[m_psel] : m_samp;
      if (we && sel == 2) begin m_phase = wdata; m_carry = 1'b0; end
      else if (c) begin m_phase = s[31:0]; m_carry = (m_mode == 1) && s[32]; end
      else m_carry = 1'b0;
      if (we && sel == 0) begin m_mode = wdata[1:0]; m_psel = wdata[10:8]; end
      if (we && sel == 1) m_freq = wdata;
      m_samp = ns;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      string tag;
      case (m_mode)
        0: tag = "R2";
        1: tag = "R3";
        2: tag = "R4 R12";
        default: tag = "R5 R12";
      endcase
      check(phase == m_phase, {tag, " model phase"}, phase, m_phase);
      check(pin == (m_carry && m_mode == 1), {tag, " model pin"}, {31'd0, pin},
            {31'd0, m_carry && m_mode == 1});
    end
  end

  task automatic put(input logic [1:0] s, input logic [31:0] d);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk); #1;
  endtask

  task automatic idle(input int n);
    we = 1'b0;
    repeat (n) @(negedge clk);
    #1;
  endtask

  localparam logic [31:0] LOGIC_HI_P2 = 32'h0000_0202;
  localparam logic [31:0] LOGIC_LO_P2 = 32'h0000_0203;

  initial begin
    int highs;
    repeat (3) @(negedge clk);
    #1;
    check(phase == 0, "R1 reset phase", phase, 0);
    check(pin == 1'b0, "R1 reset pin", {31'd0, pin}, 0);
    rst_n = 1'b1;
    idle(2);

    // addend loaded before enabling: stale sample of 1 adds once
    put(2'd1, 32'd5);
    put(2'd0, LOGIC_HI_P2);
    put(2'd1, 32'd0);
    idle(3);
    check(phase == 32'd5, "R7 R9 ghost increment", phase, 32'd5);

    // recreate a stale 1, then enable first and load addend after
    pins = 8'h04;
    idle(2);
    put(2'd0, 32'd0);
    put(2'd2, 32'd0);
    pins = 8'h00;
    idle(2);
    put(2'd0, LOGIC_HI_P2);
    put(2'd1, 32'd7);
    idle(3);
    check(phase == 32'd0, "R8 no ghost", phase, 32'd0);

    // one-clock lag
    pins = 8'h04;
    idle(1);
    check(phase == 32'd0, "R4 lag first clock", phase, 32'd0);
    idle(1);
    check(phase == 32'd7, "R4 counts after sample", phase, 32'd7);
    pins = 8'h00;
    idle(1);
    idle(2);
    check(phase == 32'd14, "R4 pulse of two samples", phase, 32'd14);

    pins = 8'hFB;
    idle(5);
    check(phase == 32'd14, "R6 unselected pins ignored", phase, 32'd14);

    pins = 8'h00;
    put(2'd0, LOGIC_LO_P2);
    idle(4);
    check(phase == 32'd42, "R5 counts on low", phase, 32'd42);
    pins = 8'h04;
    idle(1);
    idle(2);
    check(phase == 32'd49, "R5 stops on high", phase, 32'd49);
    check(pin == 1'b0, "R12 pin low in logic mode", {31'd0, pin}, 0);

    // duty mode pulse rate
    put(2'd0, 32'd0);
    put(2'd2, 32'd0);
    put(2'd1, 32'h1000_0000);
    put(2'd0, 32'd1);
    highs = 0;
    for (int i = 0; i < 64; i++) begin
      idle(1);
      if (pin) highs++;
    end
    check(highs == 4, "R3 duty 1 in 16", highs, 4);

    put(2'd2, 32'hF000_0000);
    check(phase == 32'hF000_0000, "R10 direct phase write", phase, 32'hF000_0000);
    check(pin == 1'b0, "R10 carry cleared", {31'd0, pin}, 0);
    idle(1);
    check(phase == 32'd0, "R3 wrap", phase, 32'd0);
    check(pin == 1'b1, "R3 carry next cycle", {31'd0, pin}, 1);

    put(2'd1, 32'd0);
    check(phase == 32'h1000_0000, "R9 old addend on write clock", phase, 32'h1000_0000);
    idle(2);
    check(phase == 32'h1000_0000, "R9 zero addend afterwards", phase, 32'h1000_0000);

    // off mode and ignored select
    put(2'd0, 32'd0);
    put(2'd2, 32'd10);
    put(2'd1, 32'd1);
    put(2'd3, 32'd5);
    idle(3);
    check(phase == 32'd10, "R11 R2 no mode change", phase, 32'd10);
    check(pin == 1'b0, "R2 pin low when off", {31'd0, pin}, 0);
    put(2'd0, 32'd1);
    idle(1);
    check(phase == 32'd11, "R11 addend kept", phase, 32'd11);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule